// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small memory-mapped bank of chip control registers. It sits behind a simple register bus with an address, write data, a write strobe and read data. Software reaches the control words only after it opens the bank with a two-step key sequence. Some words carry extra protection on top of that.

The bank starts out locked. To open it, software writes a first key to one kick register and then a second key to a second kick register. Any other write to a kick register closes the bank again. One control word also needs a separate lock register to hold a fixed key. Some control bits, and one whole control word, can be set only once between resets.

The bank also presents fuse and status values that arrive on input ports. These are a device-status word, a 4-bit silicon revision and a six-byte MAC address. It holds a privilege-permission word with a fixed reset default, and it drives a peripheral reset line. The bus has no handshake: every write completes in the cycle its strobe is high, and there is no back-pressure. Read data is combinational from the address and is valid in the same cycle.

Top module: `keyed_cfg_bank`

## Requirements
- R1: After reset the bank is locked, and these registers read as follows: lock word 0, control word 0, device-control word 0, RMII reset bit 0, privilege word 0xAAAAAAAA.
- R2: The bank opens only after two writes in order: 0x83E70B13 to kick register 0 at byte offset 0x38, then 0x95A4F1E0 to kick register 1 at 0x3C. While open, the protected registers at 0x40004, 0x40008, 0x40020, 0x4002C and 0x41C accept writes, subject to R5 to R7.
- R3: The bank returns to locked in three cases: kick register 0 is written with any value other than its key; kick register 1 is written with any value other than its key; or kick register 1 is written while kick register 0 has not just received its key. Writing the key to kick register 0 always arms the bank and leaves it closed until kick register 1 receives its key.
- R4: Writes to protected registers while the bank is not open are dropped. Reads are allowed at all times.
- R5: The control word at 0x40008 accepts a write only when the bank is open and the lock word at 0x40004 holds 0x0F0A0B00.
- R6: Control-word bits in the write-once mask (default: bits 7:0) take the value of the first accepted write after reset. A sticky per-bit flag then freezes them until reset. The other bits follow every accepted write.
- R7: The device-control word at 0x4002C is written at most once per reset. Only the first write accepted under the open bank takes effect.
- R8: Bit 18 of the word at 0x40020 is writable while the bank is open and drives rmii_rst_o. The other bits of that word read 0.
- R9: Offset 0x0 reads devstat_i. Offset 0x8 reads silrev_i in bits 31:28 and zero elsewhere. Both are read-only, and writes to them have no effect.
- R10: The privilege word at 0x41C is writable while the bank is open and drives privperm_o.
- R11: Offset 0x700 reads MAC bytes 1 to 4, with byte 1 in bits 31:24 and byte 1 being mac_fuse_i[47:40]. Offset 0x704 reads bytes 5 and 6 in bits 31:16 and zero in bits 15:0.
- R12: The kick registers and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 19 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| devstat_i | input | 32 | Device-status word |
| silrev_i | input | 4 | Silicon revision |
| mac_fuse_i | input | 48 | MAC address, byte 1 in bits 47:40 |
| ctrl_o | output | 32 | Control word (lock-key guarded) |
| devctl_o | output | 32 | Write-once device-control word |
| privperm_o | output | 32 | Privilege-permission word |
| rmii_rst_o | output | 1 | Peripheral RMII reset |

## Verification
The hardest state to reach from the ports is a frozen write-once bit in the control word. Reaching it needs three things in order: a correct two-step kick, the lock key already in place, and then a first accepted control write. A later reset must also clear it.

The bench builds this state deliberately in three ways. It sweeps every lock value that differs from the key in one bit, which guards the control write. It sweeps all eight orderings and key combinations of the kick pair. It then runs a long pseudo-random mix in which the kick and lock keys are injected with high probability. That mix visits armed, open and relocked states in every order, and it includes a reset in the middle of the run.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_DEVSTAT = 19'h00000;
  localparam logic [ADDR_W-1:0] A_SILREV  = 19'h00008;
  localparam logic [ADDR_W-1:0] A_KICK0   = 19'h00038;
  localparam logic [ADDR_W-1:0] A_KICK1   = 19'h0003C;
  localparam logic [ADDR_W-1:0] A_MAC_HI  = 19'h00700;
  localparam logic [ADDR_W-1:0] A_MAC_LO  = 19'h00704;
  localparam logic [ADDR_W-1:0] A_PRIV    = 19'h0041C;
  localparam logic [ADDR_W-1:0] A_LOCK    = 19'h40004;
  localparam logic [ADDR_W-1:0] A_CTRL    = 19'h40008;
  localparam logic [ADDR_W-1:0] A_RMII    = 19'h40020;
  localparam logic [ADDR_W-1:0] A_DEVCTL  = 19'h4002C;

  localparam logic [DATA_W-1:0] KICK0_KEY = 32'h83E7_0B13;
  localparam logic [DATA_W-1:0] KICK1_KEY = 32'h95A4_F1E0;
  localparam logic [DATA_W-1:0] LOCK_KEY  = 32'h0F0A_0B00;

  localparam int SILREV_W  = 4;
  localparam int SILREV_LO = 28;
  localparam int MAC_W     = 48;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } kick_state_e;
endpackage

// File: rtl/cfgbank_kick.sv
module cfgbank_kick
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output kick_state_e       state_o
);
  kick_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      if (addr == A_KICK0) begin
        state_d = (wdata == KICK0_KEY) ? KS_ARMED : KS_LOCKED;
      end else if (addr == A_KICK1) begin
        if (wdata == KICK1_KEY && state_q != KS_LOCKED) state_d = KS_OPEN;
        else                                             state_d = KS_LOCKED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cfgbank_wo_reg.sv
module cfgbank_wo_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] WO_MASK = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ok,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WO_MASK[i]) begin : g_once
      logic q, f;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= RST_VAL[i];
          f <= 1'b0;
        end else if (wr_ok) begin
          if (!f) q <= wdata[i];
          f <= 1'b1;
        end
      end
      assign q_o[i]    = q;
      assign flag_o[i] = f;
    end else begin : g_free
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_VAL[i];
        else if (wr_ok) q <= wdata[i];
      end
      assign q_o[i]    = q;
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
#(
  parameter int RMII_BIT = 18
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   devstat,
  input  logic [SILREV_W-1:0] silrev,
  input  logic [MAC_W-1:0]    mac,
  input  logic [DATA_W-1:0]   lock_w,
  input  logic [DATA_W-1:0]   ctrl_w,
  input  logic [DATA_W-1:0]   devctl_w,
  input  logic [DATA_W-1:0]   priv_w,
  input  logic                rmii_w,
  output logic [DATA_W-1:0]   rdata
);
  localparam int PAD_W = DATA_W - SILREV_W;
  localparam int MAC_HI_LO = MAC_W - DATA_W;

  always_comb begin
    rdata = '0;
    case (addr)
      A_DEVSTAT: rdata = devstat;
      A_SILREV:  rdata[SILREV_LO +: SILREV_W] = silrev;
      A_MAC_HI:  rdata = mac[MAC_W-1 -: DATA_W];
      A_MAC_LO:  rdata[DATA_W-1 -: MAC_HI_LO] = mac[MAC_HI_LO-1:0];
      A_PRIV:    rdata = priv_w;
      A_LOCK:    rdata = lock_w;
      A_CTRL:    rdata = ctrl_w;
      A_RMII:    rdata[RMII_BIT] = rmii_w;
      A_DEVCTL:  rdata = devctl_w;
      default:   rdata = '0;
    endcase
  end

  logic unused_pad;
  assign unused_pad = (PAD_W == 0);
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter logic [31:0] CTRL_WO_MASK = 32'h0000_00FF,
  parameter logic [31:0] PRIV_RST     = 32'hAAAA_AAAA,
  parameter int          RMII_BIT     = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [18:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  input  logic [31:0] devstat_i,
  input  logic [3:0]  silrev_i,
  input  logic [47:0] mac_fuse_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] devctl_o,
  output logic [31:0] privperm_o,
  output logic        rmii_rst_o
);
  kick_state_e       kick_state;
  logic              bank_open;
  logic [DATA_W-1:0] lock_q, priv_q;
  logic              rmii_q;
  logic [DATA_W-1:0] ctrl_q, ctrl_flag;
  logic [DATA_W-1:0] dev_q, dev_flag;
  logic              open_wr, ctrl_ok, dev_ok;

  cfgbank_kick u_kick (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .state_o (kick_state)
  );

  assign bank_open = (kick_state == KS_OPEN);
  assign open_wr   = bank_open && bus_we;
  assign ctrl_ok   = open_wr && (bus_addr == A_CTRL) && (lock_q == LOCK_KEY);
  assign dev_ok    = open_wr && (bus_addr == A_DEVCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      priv_q <= PRIV_RST;
      rmii_q <= 1'b0;
    end else if (open_wr) begin
      if (bus_addr == A_LOCK) lock_q <= bus_wdata;
      if (bus_addr == A_PRIV) priv_q <= bus_wdata;
      if (bus_addr == A_RMII) rmii_q <= bus_wdata[RMII_BIT];
    end
  end

  cfgbank_wo_reg #(
    .W       (DATA_W),
    .WO_MASK (CTRL_WO_MASK),
    .RST_VAL ('0)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (ctrl_ok),
    .wdata  (bus_wdata),
    .q_o    (ctrl_q),
    .flag_o (ctrl_flag)
  );

  cfgbank_wo_reg #(
    .W       (DATA_W),
    .WO_MASK ({DATA_W{1'b1}}),
    .RST_VAL ('0)
  ) u_devctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (dev_ok),
    .wdata  (bus_wdata),
    .q_o    (dev_q),
    .flag_o (dev_flag)
  );

  cfgbank_rdmux #(.RMII_BIT(RMII_BIT)) u_rd (
    .addr     (bus_addr),
    .devstat  (devstat_i),
    .silrev   (silrev_i),
    .mac      (mac_fuse_i),
    .lock_w   (lock_q),
    .ctrl_w   (ctrl_q),
    .devctl_w (dev_q),
    .priv_w   (priv_q),
    .rmii_w   (rmii_q),
    .rdata    (bus_rdata)
  );

  assign ctrl_o     = ctrl_q;
  assign devctl_o   = dev_q;
  assign privperm_o = priv_q;
  assign rmii_rst_o = rmii_q;
endmodule

// File: rtl/keyed_cfg_bank_chk.sv
module keyed_cfg_bank_chk
  import cfgbank_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [18:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_we,
  input logic [31:0] ctrl_o,
  input logic [31:0] devctl_o,
  input logic [31:0] privperm_o,
  input logic        rmii_rst_o,
  input logic [1:0]  kstate,
  input logic [31:0] lock_val,
  input logic [31:0] ctrl_flag,
  input logic [31:0] dev_flag
);
  logic is_open;
  assign is_open = (kstate == KS_OPEN);

  // R4: protected outputs hold when a write arrives while not open
  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !is_open) |=> ($stable(ctrl_o) && $stable(devctl_o) &&
                              $stable(privperm_o) && $stable(rmii_rst_o)));

  // R3: a wrong key to kick register 0 locks the bank
  p_bad_kick0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_KICK0 && bus_wdata != KICK0_KEY) |=> (kstate == KS_LOCKED));

  // R3: kick register 1 written while locked keeps it locked
  p_kick_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_KICK1 && kstate == KS_LOCKED) |=> (kstate == KS_LOCKED));

  // R2: opening requires the second key on kick register 1
  p_open_kick1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_open) |-> $past(bus_we && bus_addr == A_KICK1 && bus_wdata == KICK1_KEY));

  // R5: a control write without the lock key leaves the word unchanged
  p_ctrl_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && lock_val != LOCK_KEY) |=> $stable(ctrl_o));

  // R6: written flags never clear outside reset
  p_wo_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ctrl_flag) & ~ctrl_flag) == 32'h0));

  // R6: flagged bits never change
  p_wo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((ctrl_o ^ $past(ctrl_o)) & $past(ctrl_flag)) == 32'h0));

  // R7: the device-control word is frozen once written
  p_devctl_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|dev_flag) |-> $stable(devctl_o));

  // R8: the reset line moves only after an open write to its word
  p_rmii_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rmii_rst_o) |-> $past(bus_we && bus_addr == A_RMII && is_open));
endmodule

bind keyed_cfg_bank keyed_cfg_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .ctrl_o     (ctrl_o),
  .devctl_o   (devctl_o),
  .privperm_o (privperm_o),
  .rmii_rst_o (rmii_rst_o),
  .kstate     (kick_state),
  .lock_val   (lock_q),
  .ctrl_flag  (ctrl_flag),
  .dev_flag   (dev_flag)
);

// File: tb/keyed_cfg_bank_bench.sv
module keyed_cfg_bank_bench;
  import cfgbank_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WO_MASK = 32'h0000_00FF;
  localparam logic [18:0] ADDRS [0:13] = '{A_DEVSTAT, A_SILREV, A_KICK0, A_KICK1,
    A_MAC_HI, A_MAC_LO, A_PRIV, A_LOCK, A_CTRL, A_RMII, A_DEVCTL,
    19'h00004, 19'h40000, 19'h7FFFC};

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, devstat_i = 32'h1234_5678;
  logic [3:0]  silrev_i = 4'h3;
  logic [47:0] mac_fuse_i = 48'h0011_2233_4455;
  logic [31:0] ctrl_o, devctl_o, privperm_o;
  logic rmii_rst_o;

  int tests = 0, fails = 0;
  kick_state_e m_st;
  logic [31:0] m_lock, m_ctrl, m_flag, m_dev, m_priv;
  logic m_done, m_rmii;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_bank u_keyed_cfg_bank (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = KS_LOCKED; m_lock = '0; m_ctrl = '0; m_flag = '0;
    m_dev = '0; m_done = 1'b0; m_priv = 32'hAAAA_AAAA; m_rmii = 1'b0;
  endtask

  task automatic model_write(input logic [18:0] a, input logic [31:0] d);
    logic op;
    op = (m_st == KS_OPEN);
    case (a)
      A_KICK0: m_st = (d == KICK0_KEY) ? KS_ARMED : KS_LOCKED;
      A_KICK1: m_st = (d == KICK1_KEY && m_st != KS_LOCKED) ? KS_OPEN : KS_LOCKED;
      A_LOCK:  if (op) m_lock = d;
      A_PRIV:  if (op) m_priv = d;
      A_RMII:  if (op) m_rmii = d[18];
      A_CTRL:  if (op && m_lock == LOCK_KEY) begin
                 m_ctrl = (m_ctrl & m_flag) | (d & ~m_flag);
                 m_flag = WO_MASK;
               end
      A_DEVCTL: if (op && !m_done) begin m_dev = d; m_done = 1'b1; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_read(input logic [18:0] a);
    case (a)
      A_DEVSTAT: return devstat_i;
      A_SILREV:  return {silrev_i, 28'h0};
      A_MAC_HI:  return mac_fuse_i[47:16];
      A_MAC_LO:  return {mac_fuse_i[15:0], 16'h0};
      A_PRIV:    return m_priv;
      A_LOCK:    return m_lock;
      A_CTRL:    return m_ctrl;
      A_RMII:    return {13'h0, m_rmii, 18'h0};
      A_DEVCTL:  return m_dev;
      default:   return 32'h0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_we = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [18:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [18:0] a);
    bus_addr = a; #1;
    check(req, bus_rdata, exp_read(a));
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 14; i++) rd_chk(req, ADDRS[i]);
    check({req, " ctrl_o"}, ctrl_o, m_ctrl);
    check({req, " devctl_o"}, devctl_o, m_dev);
    check({req, " privperm_o"}, privperm_o, m_priv);
    check({req, " rmii_rst_o"}, {31'h0, rmii_rst_o}, {31'h0, m_rmii});
  endtask

  task automatic open_bank();
    wr(A_KICK0, KICK0_KEY); wr(A_KICK1, KICK1_KEY);
  endtask

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
    return seed;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state
    chk_all("R1");
    check("R1 privperm default", privperm_o, 32'hAAAA_AAAA);

    // R4 writes while locked are dropped
    for (int i = 0; i < 14; i++)
      if (ADDRS[i] != A_KICK0 && ADDRS[i] != A_KICK1) wr(ADDRS[i], 32'hFFFF_FFFF);
    chk_all("R4");
    check("R4 ctrl untouched", ctrl_o, 32'h0);

    // R2/R3 sweep over key correctness and ordering
    for (int c = 0; c < 8; c++) begin
      logic [31:0] v;
      wr(A_KICK0, 32'h0);
      v = 32'h5000_0000 + c;
      if (c[2] == 1'b0) begin
        wr(A_KICK0, c[0] ? KICK0_KEY : ~KICK0_KEY);
        wr(A_KICK1, c[1] ? KICK1_KEY : KICK1_KEY ^ 32'h1);
      end else begin
        wr(A_KICK1, c[1] ? KICK1_KEY : KICK1_KEY ^ 32'h1);
        wr(A_KICK0, c[0] ? KICK0_KEY : ~KICK0_KEY);
      end
      wr(A_PRIV, v);
      rd_chk("R2/R3 kick combo", A_PRIV);
      check("R3 open only for in-order keys", privperm_o,
            (c == 3) ? v : m_priv);
    end

    // R3: re-arming from open closes the bank
    open_bank(); wr(A_PRIV, 32'h0000_1111);
    wr(A_KICK0, KICK0_KEY); wr(A_PRIV, 32'h0000_2222);
    check("R3 armed drops write", privperm_o, 32'h0000_1111);
    wr(A_KICK1, 32'h0); wr(A_PRIV, 32'h0000_3333);
    check("R3 bad kick1 relocks", privperm_o, 32'h0000_1111);

    // R5 sweep: control only accepted under exact lock key
    open_bank();
    for (int b = 0; b < 32; b++) begin
      wr(A_LOCK, LOCK_KEY ^ (32'h1 << b));
      wr(A_CTRL, 32'hFFFF_FF00 ^ b);
      check("R5 near-key lock rejects", ctrl_o, 32'h0);
    end
    wr(A_LOCK, LOCK_KEY);
    rd_chk("R5 lock readback", A_LOCK);
    // R6 first accepted write freezes the write-once bits
    wr(A_CTRL, 32'h1234_5678);
    check("R5 ctrl accepted", ctrl_o, 32'h1234_5678);
    wr(A_CTRL, 32'hFFFF_FFFF);
    check("R6 wo bits frozen", ctrl_o, 32'hFFFF_FF78);
    wr(A_CTRL, 32'h0);
    check("R6 free bits follow", ctrl_o, 32'h0000_0078);

    // R7 device-control once
    wr(A_DEVCTL, 32'hCAFE_0001);
    wr(A_DEVCTL, 32'h0BAD_0002);
    check("R7 devctl once", devctl_o, 32'hCAFE_0001);

    // R8 sweep over bit positions of the RMII word
    for (int b = 0; b < 32; b++) begin
      wr(A_RMII, 32'h1 << b);
      check("R8 rmii line", {31'h0, rmii_rst_o}, (b == 18) ? 32'h1 : 32'h0);
      rd_chk("R8 rmii readback", A_RMII);
    end

    // R9/R11 read-only values across input patterns
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      silrev_i = s[3:0];
      devstat_i = 32'h0101_0101 * s;
      mac_fuse_i = {8'(s), 8'(s+1), 8'(s+2), 8'(s+3), 8'(s+4), 8'(s+5)};
      wr(A_SILREV, 32'hFFFF_FFFF); wr(A_DEVSTAT, 32'h0);
      rd_chk("R9 silrev", A_SILREV);
      check("R9 silrev field", bus_rdata, {4'(s), 28'h0});
      rd_chk("R9 devstat", A_DEVSTAT);
      rd_chk("R11 mac hi", A_MAC_HI);
      rd_chk("R11 mac lo", A_MAC_LO);
    end

    // R10 privilege word
    wr(A_PRIV, 32'h5555_0000);
    check("R10 privperm", privperm_o, 32'h5555_0000);
    // R12 kick and unmapped reads
    rd_chk("R12 kick0", A_KICK0); rd_chk("R12 kick1", A_KICK1);
    rd_chk("R12 unmapped", 19'h40000);

    // Mixed stress with a reset in the middle; R1 flags cleared
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      logic [18:0] a;
      logic [31:0] d;
      if (n == 700) begin do_reset(); chk_all("R1 mid reset"); end
      r = nxt();
      a = ADDRS[r[3:0] % 11];
      d = nxt();
      if (r[5:4] != 2'b00) begin
        if (a == A_KICK0) d = KICK0_KEY;
        if (a == A_KICK1) d = KICK1_KEY;
        if (a == A_LOCK)  d = LOCK_KEY;
      end
      wr(a, d);
      chk_all("R2-mix R6 R7");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule